// File: doc/BRIEF.md
# Cascaded Two/Three Modulus Clock Divider

This block divides a fast input clock by any whole number from 64 to 127. It is built as a chain of six identical cells. Each cell can divide by two or by three. A cell passes a one-cycle advance strobe forward to the next cell in the chain. It passes a modulus-control level backward to the cell before it. Over one full output period, each cell whose program bit is set swallows exactly one extra period of its own input. The bit weights therefore add up to the selected ratio.

All cells run from the one input clock. Each cell advances only on cycles where its incoming strobe is high, so no cell produces a clock of its own. The program word is copied into a shadow register only on the cycle that closes a division period, which means a period never mixes two ratios. The output is a registered copy of the first cell's modulus-control output. It is a single-cycle pulse, once per division period.

Top module: `mmd_divider`

## Requirements
- R1: With program word P on `ratio_sel` (bit 0 weighs 1, bit 5 weighs 32), consecutive `div_out` pulses are exactly 64 + P `clk_in` cycles apart.
- R2: Every ratio from 64 through 127 can be reached, one step at a time, and each gives the pulse spacing of R1.
- R3: Each `div_out` pulse is high for exactly one `clk_in` cycle.
- R4: A set program bit k lengthens the period by exactly 2^k cycles, because its cell divides by three for one of its own periods. Word 0 gives 64, word 63 gives 127, and each single-bit word gives 64 + 2^k.
- R5: A change of `ratio_sel` during a period leaves that period at the old ratio. This holds even for a change one cycle after the pulse or one cycle before the next boundary. The next period uses the new ratio.
- R6: While reset is low, and on the first cycle after reset is released internally, `div_out` stays low.
- R7: After `rst_n` rises, the first pulse comes 64 + P + 3 cycles later: two synchroniser cycles, one load cycle, then the ratio. The period that follows it already equals 64 + P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_sel | input | 6 | Program word; the ratio is 64 plus this value |
| div_out | output | 1 | One-cycle pulse per division period |

## Verification
The assertions take for granted that `ratio_sel` is steady on the cycle that closes a period. They also assume that reset is held low from time zero, so the period counter in the checker starts from a known pulse. The bench changes `ratio_sel` only on falling clock edges and never on the boundary edge itself. It places each change between zero and 63 cycles after an observed pulse, which always lands inside the current period because the shortest period is 64 cycles. The period check arms only after the first pulse, so the shorter stretch from reset to the first pulse is never compared against a full period.

// File: rtl/mmd_pkg.sv
package mmd_pkg;

  // Count state of one two/three cell, in units of its own input period.
  typedef enum logic [1:0] {
    PH_FIRST  = 2'd0,
    PH_SECOND = 2'd1,
    PH_THIRD  = 2'd2
  } cell_phase_e;

  // The modulus input of the last cell is held asserted.
  localparam logic TAIL_MOD_LEVEL = 1'b1;

endpackage

// File: rtl/mmd_rst_sync.sv
module mmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/mmd_cell.sv
module mmd_cell
  import mmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step_in,   // one period of this cell's input has elapsed
  input  logic mod_in,    // modulus request from the next cell
  input  logic prog_bit,  // 1: may divide by three
  output logic step_out,  // this cell completes one output period
  output logic mod_out    // modulus request toward the previous cell
);

  cell_phase_e phase_q;
  cell_phase_e phase_d;
  cell_phase_e last_phase;
  logic        at_last;
  logic        swallow;
  logic        phase_en;

  always_comb begin
    swallow    = prog_bit & mod_in;
    last_phase = swallow ? PH_THIRD : PH_SECOND;
    at_last    = (phase_q == last_phase);
    step_out   = step_in & at_last;
    mod_out    = mod_in & at_last;
    phase_en   = step_in;
  end

  always_comb begin
    phase_d = phase_q;
    if (at_last) begin
      phase_d = PH_FIRST;
    end else if (phase_q == PH_FIRST) begin
      phase_d = PH_SECOND;
    end else begin
      phase_d = PH_THIRD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
    end else if (phase_en) begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/mmd_prog_shadow.sv
module mmd_prog_shadow #(
  parameter int WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             period_end,
  input  logic [WIDTH-1:0] prog_in,
  output logic [WIDTH-1:0] prog_q,
  output logic             chain_run
);

  logic             load_pending_q;
  logic             load_pending_d;
  logic [WIDTH-1:0] prog_d;
  logic             load_en;

  always_comb begin
    load_en        = load_pending_q | period_end;
    prog_d         = prog_in;
    load_pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pending_q <= 1'b1;
    end else begin
      load_pending_q <= load_pending_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_q <= '0;
    end else if (load_en) begin
      prog_q <= prog_d;
    end
  end

  assign chain_run = ~load_pending_q;

endmodule

// File: rtl/mmd_divider.sv
module mmd_divider #(
  parameter int NUM_CELLS   = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk_in,
  input  logic                 rst_n,
  input  logic [NUM_CELLS-1:0] ratio_sel,
  output logic                 div_out
);

  import mmd_pkg::*;

  logic                 rst_sync_n;
  logic                 chain_run;
  logic [NUM_CELLS-1:0] shadow_q;
  logic [NUM_CELLS:0]   step_vec;
  logic [NUM_CELLS:0]   mod_vec;
  logic                 period_end;
  logic                 div_q;
  logic                 div_d;

  mmd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk_in),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  mmd_prog_shadow #(.WIDTH(NUM_CELLS)) u_shadow (
    .clk        (clk_in),
    .rst_n      (rst_sync_n),
    .period_end (period_end),
    .prog_in    (ratio_sel),
    .prog_q     (shadow_q),
    .chain_run  (chain_run)
  );

  assign step_vec[0]         = chain_run;
  assign mod_vec[NUM_CELLS]  = TAIL_MOD_LEVEL;

  for (genvar gi = 0; gi < NUM_CELLS; gi++) begin : g_cell
    mmd_cell u_cell (
      .clk      (clk_in),
      .rst_n    (rst_sync_n),
      .step_in  (step_vec[gi]),
      .mod_in   (mod_vec[gi+1]),
      .prog_bit (shadow_q[gi]),
      .step_out (step_vec[gi+1]),
      .mod_out  (mod_vec[gi])
    );
  end

  // Every cell wraps together on the last cycle of the full period.
  assign period_end = step_vec[NUM_CELLS];

  always_comb begin
    div_d = mod_vec[0];
  end

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      div_q <= 1'b0;
    end else begin
      div_q <= div_d;
    end
  end

  assign div_out = div_q;

endmodule

// File: rtl/mmd_divider_chk.sv
module mmd_divider_chk #(
  parameter int NUM_CELLS = 6
) (
  input logic                 clk_in,
  input logic                 rst_sync_n,
  input logic                 div_out,
  input logic                 chain_run,
  input logic                 period_end,
  input logic [NUM_CELLS-1:0] shadow_q
);

  localparam int CW = NUM_CELLS + 2;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [CW-1:0] since_q;
  logic [CW-1:0] ratio_q;
  logic          armed_q;

  always_ff @(posedge clk_in or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      since_q <= '0;
      ratio_q <= '0;
      armed_q <= 1'b0;
    end else if (div_out) begin
      since_q <= CW'(1);
      ratio_q <= CW'({1'b1, shadow_q});
      armed_q <= 1'b1;
    end else if (since_q != CNT_MAX) begin
      since_q <= since_q + CW'(1);
    end
  end

  AST_PERIOD_MATCH: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    (div_out && armed_q) |-> (since_q == ratio_q)); // R1

  AST_PULSE_SINGLE: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    div_out |=> !div_out); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    (chain_run && !period_end) |=> $stable(shadow_q)); // R5

  AST_QUIET_LOAD: assert property (@(posedge clk_in) disable iff (!rst_sync_n)
    !chain_run |-> !div_out); // R6

endmodule

bind mmd_divider mmd_divider_chk #(.NUM_CELLS(NUM_CELLS)) u_chk (
  .clk_in     (clk_in),
  .rst_sync_n (rst_sync_n),
  .div_out    (div_out),
  .chain_run  (chain_run),
  .period_end (period_end),
  .shadow_q   (shadow_q)
);

// File: tb/mmd_divider_tb.sv
module mmd_divider_tb;

  logic       clk_in = 1'b0;
  logic       rst_n;
  logic [5:0] ratio_sel;
  logic       div_out;

  always #5 clk_in = ~clk_in;

  mmd_divider u_dut (
    .clk_in    (clk_in),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .div_out   (div_out)
  );

  int    checks = 0;
  int    fails  = 0;
  int    exp_q[$];
  string tag_q[$];
  int    cur;
  int    cyc = 0;
  int    prev_cyc = 0;
  bit    have_prev = 0;
  bit    prev_hi = 0;

  task automatic report_fail(input string tag, input int act, input int exp);
    fails++;
    $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Monitor: measures pulse spacing and compares against the scoreboard.
  always @(negedge clk_in) begin
    cyc++;
    if (!rst_n) begin
      have_prev = 0;
      prev_hi   = 0;
    end else begin
      if (prev_hi) begin
        checks++;
        if (div_out) report_fail("R3 pulse width", 2, 1);
      end
      if (div_out) begin
        if (have_prev) begin
          checks++;
          if (exp_q.size() == 0) begin
            report_fail("R1 scoreboard empty", cyc - prev_cyc, 0);
          end else begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (cyc - prev_cyc != e) report_fail(t, cyc - prev_cyc, e);
          end
        end
        have_prev = 1;
        prev_cyc  = cyc;
      end
      prev_hi = div_out;
    end
  end

  task automatic wait_pulse();
    @(negedge clk_in);
    while (!div_out) @(negedge clk_in);
  endtask

  task automatic push(input int ratio, input string tag);
    exp_q.push_back(ratio);
    tag_q.push_back(tag);
  endtask

  // Driver: the period starting at the observed pulse keeps the old ratio.
  task automatic run(input int nxt, input int dly, input int reps, input string tag);
    wait_pulse();
    push(64 + cur, tag);
    repeat (dly) @(negedge clk_in);
    ratio_sel = 6'(nxt);
    for (int k = 1; k < reps; k++) begin
      wait_pulse();
      push(64 + nxt, tag);
    end
    cur = nxt;
  endtask

  initial begin
    repeat (150000) @(posedge clk_in);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int lat;
    rst_n     = 1'b0;
    ratio_sel = 6'd37;
    cur       = 37;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_in);
      checks++;
      if (div_out !== 1'b0) report_fail("R6 reset output", int'(div_out), 0);
    end
    rst_n = 1'b1;
    lat = 0;
    do begin
      @(negedge clk_in);
      lat++;
      if (lat <= 3) begin
        checks++;
        if (div_out !== 1'b0) report_fail("R6 load cycle output", int'(div_out), 0);
      end
    end while (!div_out && lat < 1000);
    checks++;
    if (lat != 64 + 37 + 3) report_fail("R7 first pulse latency", lat, 64 + 37 + 3);
    push(64 + 37, "R7 first period");

    run(37, 10, 3, "R1 steady 101");
    run(0, 20, 2, "R4 word 0");
    run(63, 63, 2, "R4 word 63");
    for (int b = 0; b < 6; b++) run(1 << b, 5 + b, 2, "R4 single bit");

    for (int r = 0; r < 64; r++) run(r, (r * 7) % 64, 2, "R2 sweep");

    run(5, 0, 1, "R5 change after pulse");
    run(60, 63, 1, "R5 change before boundary");
    run(17, 31, 2, "R5 change mid period");
    run(40, 1, 2, "R5 change early");
    wait_pulse();
    @(negedge clk_in);

    checks++;
    if (exp_q.size() != 0) report_fail("R1 scoreboard drain", exp_q.size(), 0);

    summary();
    $finish;
  end

endmodule